// File: doc/BRIEF.md
# Redundant-Coded S-Box Substitution Unit

This unit applies the cipher byte substitution to a 16-bit redundant ring element. The data byte is never present in the clear anywhere in the datapath. A value arrives as a two-coefficient polynomial `hi·y + lo` over GF(2^8). It carries a data byte xD and a check byte xC. These combine through the remainder theorem on the two linear factors (y + A1) and (y + A2). The unit first isolates the check part and forms the difference to a fixed entry signature. It then forces the operand onto that signature and indexes two constant tables. Finally it adds the difference back. The check byte of the result therefore still depends on the check byte of the operand, and the protection chain is not broken.

The two tables are computed at elaboration from the ring constants. The main table has 256 entries of 16 bits, indexed by the high coefficient. The correction table has 256 entries of 8 bits, indexed by the low coefficient. Each main entry carries an error term that only the matching correction entry cancels. The caller supplies the operand, the normalization term m = XCIN·i2 and the idempotent i2. The unit is a three-stage pipeline with a valid flag and accepts one operand per cycle. Its stages are isolate (ring multiply by i2), normalize-and-look-up, and restore.

Top module: `rsub_pipe`

## Requirements
- R1: Arithmetic is in GF(2^8) modulo x^8+x^4+x^3+x+1. A word w = {hi[15:8], lo[7:0]} has data byte hi·A1 ^ lo and check byte hi·A2 ^ lo. For a valid operand with data xD and check xC, given i2 = {s, A1·s} with s = 1/(A1^A2) and m = {XCIN·s, XCIN·A1·s}, the result has data byte SubBytes(xD).
- R2: The check byte of the result equals xC ^ XCIN ^ XCOUT, for every xC.
- R3: Inside the unit, multiplying the operand by i2 leaves a term whose data byte is zero. The operand presented to the tables carries check byte XCIN.
- R4: A normalization term m other than the one in R1 yields a result that is not the correct codeword of R1/R2.
- R5: An operand with any single flipped bit yields a result that differs from the correct codeword of the unflipped operand.
- R6: With XCIN != XCOUT, the check byte of the result always differs from the check byte of the operand.
- R7: out_valid rises exactly three clock edges after the edge that samples in_valid high. Operands on consecutive cycles come out on consecutive cycles in order, and out_valid is low three edges after in_valid is low.
- R8: A synchronous active-high rst clears out_valid and v_out to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand qualifier |
| u_in | input | 16 | Encoded operand {hi, lo} |
| m_in | input | 16 | Normalization term XCIN·i2 |
| i2_in | input | 16 | Check idempotent |
| out_valid | output | 1 | Result qualifier |
| v_out | output | 16 | Encoded result {hi, lo} |

## Verification
A wrong isolation product or a wrong normalization makes the two table indices point at different data bytes. The uncancelled error term then shows up in both decoded bytes of v_out three cycles after the operand. A table entry built from the wrong signature shows as a check byte off by a constant for every operand that reaches it. Because the bench sweeps all 256 check values and several data bytes, such faults appear at the ports on the first affected result. A broken valid shift shows as a misplaced or missing out_valid pulse at the third edge.

// File: rtl/rsub_pkg.sv
package rsub_pkg;

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1B : 8'h00);
        end
        return acc;
    endfunction

    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] r;
        logic [7:0] p;
        r = 8'h01;
        p = a;
        for (int i = 0; i < 8; i++) begin
            if (i != 0) r = gf_mul(r, p);
            p = gf_mul(p, p);
        end
        return r;
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] b, input int n);
        return (b << n) | (b >> (8 - n));
    endfunction

    function automatic logic [7:0] subst(input logic [7:0] x);
        logic [7:0] b;
        b = gf_inv(x);
        return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
    endfunction

    // value of the ring word at y = pt (residue modulo y + pt)
    function automatic logic [7:0] ring_eval(input logic [15:0] w, input logic [7:0] pt);
        return gf_mul(w[15:8], pt) ^ w[7:0];
    endfunction

    // build the word whose residues at a1 and a2 are xd and xc
    function automatic logic [15:0] ring_enc(input logic [7:0] xd, input logic [7:0] xc,
                                             input logic [7:0] a1, input logic [7:0] a2);
        logic [7:0] s;
        s = gf_inv(a1 ^ a2);
        return {gf_mul(xd ^ xc, s), gf_mul(gf_mul(xd, a2) ^ gf_mul(xc, a1), s)};
    endfunction

endpackage

// File: rtl/rsub_ring_mul.sv
module rsub_ring_mul
    import rsub_pkg::*;
#(
    parameter logic [7:0] A1 = 8'h1B,
    parameter logic [7:0] A2 = 8'h35
) (
    input  logic [15:0] op_a,
    input  logic [15:0] op_b,
    output logic [15:0] prod
);
    localparam logic [7:0] C1 = A1 ^ A2;
    localparam logic [7:0] C0 = gf_mul(A1, A2);

    logic [7:0] hh;
    always_comb begin
        hh   = gf_mul(op_a[15:8], op_b[15:8]);
        prod = {gf_mul(hh, C1) ^ gf_mul(op_a[15:8], op_b[7:0]) ^ gf_mul(op_a[7:0], op_b[15:8]),
                gf_mul(hh, C0) ^ gf_mul(op_a[7:0], op_b[7:0])};
    end
endmodule

// File: rtl/rsub_tables.sv
module rsub_tables
    import rsub_pkg::*;
#(
    parameter logic [7:0] A1    = 8'h1B,
    parameter logic [7:0] A2    = 8'h35,
    parameter logic [7:0] XCIN  = 8'hA7,
    parameter logic [7:0] XCOUT = 8'h3C,
    parameter logic [7:0] EMASK = 8'h5A,
    parameter int         N     = 256
) (
    input  logic [7:0]  idx_hi,
    input  logic [7:0]  idx_lo,
    output logic [15:0] main_q,
    output logic [7:0]  corr_q
);
    localparam logic [7:0] SUM   = A1 ^ A2;
    localparam logic [7:0] A2INV = gf_inv(A2);

    function automatic logic [15:0] main_entry(input logic [7:0] j);
        logic [7:0] x;
        logic [7:0] sx;
        x  = gf_mul(j, SUM) ^ XCIN;
        sx = subst(x);
        return ring_enc(sx, XCOUT, A1, A2) ^ {8'h00, sx ^ EMASK};
    endfunction

    function automatic logic [7:0] corr_entry(input logic [7:0] k);
        logic [7:0] x;
        x = gf_mul(gf_mul(k, SUM) ^ gf_mul(XCIN, A1), A2INV);
        return subst(x) ^ EMASK;
    endfunction

    logic [15:0] main_rom [N];
    logic [7:0]  corr_rom [N];

    for (genvar j = 0; j < N; j++) begin : g_rom
        assign main_rom[j] = main_entry(8'(j));
        assign corr_rom[j] = corr_entry(8'(j));
    end

    assign main_q = main_rom[idx_hi];
    assign corr_q = corr_rom[idx_lo];
endmodule

// File: rtl/rsub_pipe.sv
module rsub_pipe
    import rsub_pkg::*;
#(
    parameter logic [7:0] A1    = 8'h1B,
    parameter logic [7:0] A2    = 8'h35,
    parameter logic [7:0] XCIN  = 8'hA7,
    parameter logic [7:0] XCOUT = 8'h3C
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [15:0] u_in,
    input  logic [15:0] m_in,
    input  logic [15:0] i2_in,
    output logic        out_valid,
    output logic [15:0] v_out
);
    localparam logic [7:0]  S_INV  = gf_inv(A1 ^ A2);
    localparam logic [15:0] I2_REF = {S_INV, gf_mul(A1, S_INV)};
    localparam logic [15:0] M_REF  = {gf_mul(XCIN, S_INV), gf_mul(gf_mul(XCIN, A1), S_INV)};

    // stage 1: isolate check part and form signature difference
    logic [15:0] t_iso;
    logic [15:0] u_s1, d_s1;
    logic        v_s1;

    rsub_ring_mul #(.A1(A1), .A2(A2)) i_iso (
        .op_a (u_in),
        .op_b (i2_in),
        .prod (t_iso)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            v_s1 <= 1'b0;
            u_s1 <= '0;
            d_s1 <= '0;
        end else begin
            v_s1 <= in_valid;
            u_s1 <= u_in;
            d_s1 <= t_iso ^ m_in;
        end
    end

    // stage 2: normalize to XCIN and look up both tables
    logic [15:0] u_norm;
    logic [15:0] main_q;
    logic [7:0]  corr_q;
    logic [15:0] main_s2, d_s2;
    logic [7:0]  corr_s2;
    logic        v_s2;

    assign u_norm = u_s1 ^ d_s1;

    rsub_tables #(.A1(A1), .A2(A2), .XCIN(XCIN), .XCOUT(XCOUT)) i_tab (
        .idx_hi (u_norm[15:8]),
        .idx_lo (u_norm[7:0]),
        .main_q (main_q),
        .corr_q (corr_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            v_s2    <= 1'b0;
            main_s2 <= '0;
            corr_s2 <= '0;
            d_s2    <= '0;
        end else begin
            v_s2    <= v_s1;
            main_s2 <= main_q;
            corr_s2 <= corr_q;
            d_s2    <= d_s1;
        end
    end

    // stage 3: cancel error term and restore the signature difference
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            v_out     <= '0;
        end else begin
            out_valid <= v_s2;
            v_out     <= main_s2 ^ {8'h00, corr_s2} ^ d_s2;
        end
    end

    // R3: product with a proper idempotent has no data residue
    assert_isolate_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && i2_in == I2_REF) |-> (ring_eval(t_iso, A1) == 8'h00));

    // R3: table operand carries the entry signature after a proper m
    assert_norm_sig_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && i2_in == I2_REF && m_in == M_REF) |=> (ring_eval(u_norm, A2) == XCIN));

    // R7: a sampled operand leaves three edges later
    assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##3 out_valid);

    // R7: no result without an operand
    assert_no_spurious_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##3 !out_valid);

    // R6: every proper result has moved off the operand's signature
    assert_sig_moved_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && i2_in == I2_REF && m_in == M_REF) |-> ##3
        (ring_eval(v_out, A2) == (ring_eval($past(u_in, 3), A2) ^ XCIN ^ XCOUT)));
endmodule

// File: tb/test_rsub_pipe.sv
module test_rsub_pipe;
    localparam logic [7:0] A1    = 8'h1B;
    localparam logic [7:0] A2    = 8'h35;
    localparam logic [7:0] XCIN  = 8'hA7;
    localparam logic [7:0] XCOUT = 8'h3C;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [15:0] u_in, m_in, i2_in;
    logic        out_valid;
    logic [15:0] v_out;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    rsub_pipe #(.A1(A1), .A2(A2), .XCIN(XCIN), .XCOUT(XCOUT)) i_rsub_pipe (
        .clk(clk), .rst(rst), .in_valid(in_valid), .u_in(u_in),
        .m_in(m_in), .i2_in(i2_in), .out_valid(out_valid), .v_out(v_out)
    );

    function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r = 0;
        logic [7:0] p = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r ^= p;
            p = {p[6:0], 1'b0} ^ (p[7] ? 8'h1B : 8'h00);
        end
        return r;
    endfunction

    function automatic logic [7:0] binv(input logic [7:0] a);
        for (int c = 1; c < 256; c++)
            if (bmul(a, 8'(c)) == 8'h01) return 8'(c);
        return 8'h00;
    endfunction

    function automatic logic [15:0] enc(input logic [7:0] xd, input logic [7:0] xc);
        logic [7:0] s = binv(A1 ^ A2);
        return {bmul(xd ^ xc, s), bmul(bmul(xd, A2) ^ bmul(xc, A1), s)};
    endfunction

    function automatic logic [7:0] dec(input logic [15:0] w, input logic [7:0] pt);
        return bmul(w[15:8], pt) ^ w[7:0];
    endfunction

    function automatic logic [7:0] sref(input int k);
        case (k)
            0: return 8'h63; 1: return 8'h7C; 2: return 8'h77; 3: return 8'h7B;
            4: return 8'hCA; 5: return 8'h82; 6: return 8'hB7; 7: return 8'hED;
            8: return 8'hCD; default: return 8'h16;
        endcase
    endfunction

    function automatic logic [7:0] xref(input int k);
        case (k)
            0: return 8'h00; 1: return 8'h01; 2: return 8'h02; 3: return 8'h03;
            4: return 8'h10; 5: return 8'h11; 6: return 8'h20; 7: return 8'h53;
            8: return 8'h80; default: return 8'hFF;
        endcase
    endfunction

    logic [7:0]  s_c;
    logic [15:0] i2_ok, m_ok;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_ne(input string req, input logic [15:0] act, input logic [15:0] bad);
        n_chk++;
        if (act === bad) begin
            n_fail++;
            $display("FAIL %s: got %h expected any value but %h", req, act, bad);
        end
    endtask

    task automatic apply(input logic [15:0] u, input logic [15:0] m, output logic [15:0] v,
                         output logic vld);
        @(negedge clk);
        u_in = u; m_in = m; i2_in = i2_ok; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        v = v_out; vld = out_valid;
    endtask

    task automatic t_reset;
        rst = 1'b1; in_valid = 1'b1; u_in = 16'hFFFF; m_in = m_ok; i2_in = i2_ok;
        repeat (4) @(negedge clk);
        check("R8 out_valid in reset", {15'd0, out_valid}, 16'd0);
        check("R8 v_out in reset", v_out, 16'd0);
        in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R8 out_valid after reset", {15'd0, out_valid}, 16'd0);
    endtask

    task automatic t_known;
        logic [15:0] v; logic vld;
        for (int k = 0; k < 10; k++) begin
            logic [7:0] xc = 8'(k * 37 + 5);
            apply(enc(xref(k), xc), m_ok, v, vld);
            check("R7 valid on result", {15'd0, vld}, 16'd1);
            check("R1 data byte", {8'd0, dec(v, A1)}, {8'd0, sref(k)});
            check("R2 check byte", {8'd0, dec(v, A2)}, {8'd0, xc ^ XCIN ^ XCOUT});
        end
    endtask

    task automatic t_sig_sweep;
        logic [15:0] v; logic vld;
        for (int c = 0; c < 256; c++) begin
            apply(enc(8'h53, 8'(c)), m_ok, v, vld);
            check("R3 any signature normalized, R1 data", v, enc(8'hED, 8'(c) ^ XCIN ^ XCOUT));
            check_ne("R6 signature moved", {8'd0, dec(v, A2)}, {8'd0, 8'(c)});
        end
    endtask

    task automatic t_stream;
        logic [15:0] exp_q [8];
        for (int n = 0; n < 12; n++) begin
            @(negedge clk);
            if (n >= 3 && n < 11) begin
                check("R7 stream valid", {15'd0, out_valid}, 16'd1);
                check("R7 stream order", v_out, exp_q[n - 3]);
            end
            if (n == 11) check("R7 valid drops", {15'd0, out_valid}, 16'd0);
            if (n < 8) begin
                u_in = enc(xref(n), 8'(n * 11));
                m_in = m_ok; i2_in = i2_ok; in_valid = 1'b1;
                exp_q[n] = enc(sref(n), 8'(n * 11) ^ XCIN ^ XCOUT);
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    task automatic t_bad_norm;
        logic [15:0] v; logic vld;
        for (int k = 1; k < 9; k++) begin
            logic [15:0] mb = m_ok ^ {bmul(8'(k), s_c), bmul(bmul(8'(k), A1), s_c)};
            apply(enc(xref(k), 8'h44), mb, v, vld);
            check_ne("R4 wrong m detected", v, enc(sref(k), 8'h44 ^ XCIN ^ XCOUT));
        end
    endtask

    task automatic t_input_fault;
        logic [15:0] v; logic vld;
        for (int b = 0; b < 16; b++) begin
            apply(enc(8'h20, 8'h9E) ^ (16'h1 << b), m_ok, v, vld);
            check_ne("R5 flipped operand bit", v, enc(8'hB7, 8'h9E ^ XCIN ^ XCOUT));
        end
    endtask

    initial begin
        s_c   = binv(A1 ^ A2);
        i2_ok = {s_c, bmul(A1, s_c)};
        m_ok  = {bmul(XCIN, s_c), bmul(bmul(XCIN, A1), s_c)};
        t_reset();
        t_known();
        t_sig_sweep();
        t_stream();
        t_bad_norm();
        t_input_fault();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule